// File: doc/BRIEF.md
# Streaming Top-4 Extreme Selector

This block watches a stream of 16-bit signed samples cut into groups and, for each group, keeps the four samples that are most extreme under one of four relations: largest, smallest, largest magnitude or smallest magnitude. When the group closes, it returns those four samples, each paired with its position inside the group. The four pairs come out in a fixed order, from the least extreme winner to the most extreme one.

A group opens with a one-cycle start pulse that carries the opcode. The samples then arrive on a valid/ready input, and the final sample of the group is flagged. The four results leave on a valid/ready output, and the fourth result is flagged as last. Input is refused while results are draining. An unknown opcode or a group of fewer than four samples raises a one-cycle error pulse and yields no output.

Top module: `topk4_select`

## Requirements
- R1: The opcode byte sampled with `start` selects MIN = 0x08, MAX = 0x09, ABS_MIN = 0x20 or ABS_MAX = 0x21. Any other value pulses `err` on the next cycle, accepts no samples (`in_ready` stays 0) and produces no output.
- R2: Every accepted group of four or more samples yields exactly four output pairs. `out_last` is 1 on the fourth pair only.
- R3: A group whose flagged last sample is its first, second or third sample pulses `err` on the cycle after that sample. It produces no output.
- R4: `out_index` is the position of the sample within its group. The first sample is position 0.
- R5: Under MAX the four largest signed samples are returned in ascending value order, so the smallest winner comes first.
- R6: Under MIN the four smallest signed samples are returned in descending value order, so the largest winner comes first.
- R7: ABS_MAX and ABS_MIN rank samples by magnitude, in the same order as R5 and R6 respectively. The value returned is the original signed sample.
- R8: When two samples have equal keys, the one with the lower index counts as more extreme.
- R9: The magnitude of -32768 saturates to 32767, so it ties with 32767 under R8.
- R10: `in_ready` is 0 while results are pending. A result held with `out_ready` low keeps its value, index and last flag unchanged. No result is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a group; samples `op` |
| op | input | 8 | Relation opcode |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Sample accepted when high with `in_valid` |
| in_data | input | DW | Signed sample |
| in_last | input | 1 | Marks the final sample of a group |
| out_valid | output | 1 | Result pair valid |
| out_ready | input | 1 | Consumer takes the pair |
| out_value | output | DW | Winning sample, signed |
| out_index | output | IW | Position of the winner in its group |
| out_last | output | 1 | Marks the fourth pair |
| err | output | 1 | One-cycle pulse for a bad opcode or a short group |

## Verification
The bench uses the default widths: a 16-bit sample and a 16-bit index. With 16-bit samples, the saturation corner (-32768 against 32767) can be driven directly. Random groups of 4 to 40 samples are drawn partly from a narrow range of -3 to 3, so equal keys, and therefore the index tie rule, turn up often. Groups of one to three samples and a rejected opcode are applied between random groups, and `out_ready` toggles randomly to exercise the hold behaviour.

// File: rtl/topk4_select.sv
module topk4_select #(
  parameter int DW = 16,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    op,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_value,
  output logic [IW-1:0] out_index,
  output logic          out_last,
  output logic          err
);
  localparam logic [7:0] OP_MIN = 8'h08, OP_MAX = 8'h09, OP_AMIN = 8'h20, OP_AMAX = 8'h21;
  localparam logic [DW-1:0] NEG_LIM = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] POS_LIM = {1'b0, {(DW-1){1'b1}}};
  localparam int K = 4;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_DRAIN} state_t;
  state_t state;

  logic [7:0]    op_q;
  logic [IW-1:0] cnt;
  logic [1:0]    ptr;
  logic [DW-1:0] sval [K];
  logic [IW-1:0] sidx [K];
  logic [K-1:0]  sv, beats;

  function automatic logic signed [DW-1:0] rank_key(input logic [DW-1:0] v, input logic mag);
    if (!mag) return v;
    if (v == NEG_LIM) return POS_LIM;
    return v[DW-1] ? -v : v;
  endfunction

  wire op_ok  = (op == OP_MIN) || (op == OP_MAX) || (op == OP_AMIN) || (op == OP_AMAX);
  wire is_min = (op_q == OP_MIN) || (op_q == OP_AMIN);
  wire is_abs = (op_q == OP_AMIN) || (op_q == OP_AMAX);
  wire take   = in_valid && in_ready;
  wire signed [DW-1:0] nkey = rank_key(in_data, is_abs);

  for (genvar i = 0; i < K; i++) begin : g_cmp
    wire signed [DW-1:0] skey = rank_key(sval[i], is_abs);
    assign beats[i] = !sv[i] || (is_min ? (nkey < skey) : (nkey > skey));
  end

  assign in_ready  = (state == S_FILL);
  assign out_valid = (state == S_DRAIN);
  assign out_value = sval[~ptr];
  assign out_index = sidx[~ptr];
  assign out_last  = (ptr == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      op_q  <= '0;
      cnt   <= '0;
      ptr   <= '0;
      err   <= 1'b0;
      sv    <= '0;
      for (int i = 0; i < K; i++) begin
        sval[i] <= '0;
        sidx[i] <= '0;
      end
    end else begin
      err <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (op_ok) begin
            state <= S_FILL;
            op_q  <= op;
            cnt   <= '0;
            sv    <= '0;
          end else begin
            err <= 1'b1;
          end
        end
        S_FILL: if (take) begin
          for (int i = K - 1; i >= 0; i--) begin
            if (i > 0 && beats[i-1]) begin
              sval[i] <= sval[i-1];
              sidx[i] <= sidx[i-1];
              sv[i]   <= sv[i-1];
            end else if (beats[i]) begin
              sval[i] <= in_data;
              sidx[i] <= cnt;
              sv[i]   <= 1'b1;
            end
          end
          cnt <= cnt + 1'b1;
          if (in_last) begin
            if (cnt < IW'(3)) begin
              err   <= 1'b1;
              state <= S_IDLE;
            end else begin
              state <= S_DRAIN;
              ptr   <= '0;
            end
          end
        end
        S_DRAIN: if (out_ready) begin
          ptr <= ptr + 1'b1;
          if (ptr == 2'd3) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/topk4_select_chk.sv
module topk4_select_chk #(
  parameter int DW = 16,
  parameter int IW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_value,
  input logic [IW-1:0] out_index,
  input logic          out_last,
  input logic          err,
  input logic [7:0]    op_q
);
  logic [1:0] ocnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ocnt <= '0;
    else if (out_valid && out_ready) ocnt <= ocnt + 1'b1;

  p_last_fourth_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (ocnt == 2'd3)));

  p_err_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid);

  p_max_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last && op_q == 8'h09) |=>
      ($signed(out_value) >= $signed($past(out_value))));

  p_min_descending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last && op_q == 8'h08) |=>
      ($signed(out_value) <= $signed($past(out_value))));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_value) && $stable(out_index) && $stable(out_last)));

  p_no_input_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
endmodule

bind topk4_select topk4_select_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_value(out_value), .out_index(out_index),
  .out_last(out_last), .err(err), .op_q(op_q)
);

// File: tb/tb_topk4_select.sv
module tb_topk4_select;
  logic clk = 0, rst_n = 0, start = 0, in_valid = 0, in_last = 0, out_ready = 0;
  logic [7:0] op = 0;
  logic [15:0] in_data = 0;
  logic in_ready, out_valid, out_last, err;
  logic [15:0] out_value, out_index;
  int errors = 0, checks = 0;
  int grp [64];
  int win [4];

  always #5 clk = ~clk;

  topk4_select dut (.*);

  function automatic int bkey(int v, bit mag);
    if (!mag) return v;
    if (v == -32768) return 32767;
    return v < 0 ? -v : v;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model(logic [7:0] o, int n);
    bit mn = (o == 8'h08 || o == 8'h20), mag = (o == 8'h20 || o == 8'h21);
    bit used [64];
    for (int i = 0; i < 64; i++) used[i] = 0;
    for (int r = 0; r < 4; r++) begin
      int b = -1;
      for (int i = 0; i < n; i++) begin
        if (used[i]) continue;
        if (b < 0) b = i;
        else if (mn ? bkey(grp[i], mag) < bkey(grp[b], mag)
                    : bkey(grp[i], mag) > bkey(grp[b], mag)) b = i;
      end
      used[b] = 1;
      win[r] = b;
    end
  endtask

  task automatic open_grp(logic [7:0] o);
    @(negedge clk); start = 1; op = o;
    @(negedge clk); start = 0;
  endtask

  task automatic send(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while ($urandom_range(3) == 0) @(negedge clk);
      in_valid = 1; in_data = grp[i][15:0]; in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 0; in_last = 0;
    end
  endtask

  task automatic run(logic [7:0] o, int n, string req);
    int got = 0;
    open_grp(o);
    send(n);
    model(o, n);
    while (got < 4) begin
      @(negedge clk);
      out_ready = ($urandom_range(2) != 0);
      if (out_valid) begin
        if (in_ready) check(0, "R10", "in_ready during drain", 1, 0);
        if (out_ready) begin
          int e = win[3 - got];
          check($signed(out_value) == grp[e] && out_index == e && out_last == (got == 3),
                req, $sformatf("pair %0d value/index", got), $signed(out_value) * 65536 + out_index,
                grp[e] * 65536 + e);
          got++;
        end
      end
    end
    @(negedge clk); out_ready = 0;
    check(!out_valid, "R2", "extra output after fourth", out_valid, 0);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!in_ready && !out_valid && !err, "R2", "reset state", {in_ready, out_valid, err}, 0);
    rst_n = 1;

    grp[0] = 3; grp[1] = -7; grp[2] = 12; grp[3] = 0;
    run(8'h09, 4, "R5");
    run(8'h08, 4, "R6");

    grp[0] = 5; grp[1] = 2; grp[2] = 2; grp[3] = 7; grp[4] = 2; grp[5] = 9; grp[6] = 2;
    run(8'h08, 7, "R8");
    run(8'h09, 7, "R4");

    grp[0] = 1; grp[1] = -32768; grp[2] = 32767; grp[3] = -2; grp[4] = 4; grp[5] = -100;
    run(8'h21, 6, "R9");
    run(8'h20, 6, "R7");

    for (int n = 1; n <= 3; n++) begin
      open_grp(8'h09);
      send(n);
      check(err == 1, "R3", $sformatf("err after short group n=%0d", n), err, 1);
      @(negedge clk);
      check(!out_valid && !in_ready, "R3", "no output after short group", out_valid, 0);
    end

    open_grp(8'h0A);
    check(err == 1, "R1", "err on bad opcode", err, 1);
    repeat (3) begin
      @(negedge clk);
      check(!in_ready && !out_valid, "R1", "idle after bad opcode", {in_ready, out_valid}, 0);
    end

    for (int t = 0; t < 60; t++) begin
      int n = $urandom_range(40, 4);
      int sel = $urandom_range(3);
      logic [7:0] o = sel == 0 ? 8'h08 : sel == 1 ? 8'h09 : sel == 2 ? 8'h20 : 8'h21;
      bit narrow = $urandom_range(1);
      for (int i = 0; i < n; i++)
        grp[i] = narrow ? int'($urandom_range(6)) - 3 : int'($signed(16'($urandom())));
      run(o, n, (o[5] ? "R7" : (o[0] ? "R5" : "R6")));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule